// File: doc/BRIEF.md
# Status Register and Write-Protection Control

This block sits behind the serial front end of a small byte-addressed nonvolatile memory. The front end decodes commands into single-cycle strobes: set-enable, clear-enable, status write (with its data byte), page open (with a start address) and page data bytes. The block owns the status byte and decides whether a memory or status write may go ahead. A latched enable bit, a two-bit code that locks the upper part of the array, and an active-low protect pin gate every write. The block collects up to one page of bytes, starts a self-timed write cycle when chip select rises, and reports busy until that cycle ends.

The storage array is a plain register file with a combinational read port. The block has four states:
- `ST_IDLE` takes commands.
- `ST_SR_PEND` holds an accepted status write.
- `ST_PG_LOAD` gathers page bytes.
- `ST_CYCLE` runs the write timer.

The transitions are:
- IDLE→SR_PEND on an accepted status write.
- IDLE→PG_LOAD on an accepted page open.
- SR_PEND→CYCLE and PG_LOAD→CYCLE on the chip-select rising edge (commit).
- SR_PEND→IDLE and PG_LOAD→IDLE on a protect-pin cancel.
- PG_LOAD→IDLE on a commit with no byte loaded.
- CYCLE→IDLE when the timer expires, which is the point where the data is written.

Top module: `nvm_wp_ctl`

## Requirements
- R1: The status byte reads, from bit 7 down to bit 0, as four ones, the lock code (bits 3:2), the enable latch (bit 1) and busy (bit 0). After reset it is 0xF0.
- R2: In idle, a set-enable strobe sets the latch and a clear-enable strobe clears it. Neither has an effect while busy.
- R3: A status write or page open is accepted only when the latch is set and wp_n is 1 in that cycle. Otherwise it is refused, the latch is cleared, and nothing is written.
- R4: An accepted sequence starts the write cycle on the first clock edge at which sel_n is seen rising. Busy then reads 1 for exactly WC_CYCLES cycles. When the cycle ends the data is written and the latch is cleared.
- R5: If wp_n is 0 while sel_n is 0 during a pending status write or page load, the sequence is cancelled. Nothing is written and the latch is cleared.
- R6: wp_n and sel_n have no effect on a write cycle that has already started.
- R7: Page bytes are placed starting at the offset in the low four address bits. The offset wraps from 15 to 0 within the same 16-byte page, and a later byte written to the same slot wins.
- R8: Lock code 00 locks nothing. 01 locks addresses whose two top bits are 11. 10 locks addresses whose top bit is 1. 11 locks the whole array. Bytes that fall on locked addresses are dropped, and the other bytes of the page are still written.
- R9: A status write changes only the lock code, taken from data bits 3:2. The new code takes effect when its cycle ends.
- R10: While busy, status writes and page opens are ignored.
- R11: A chip-select rise during a page load with no byte loaded starts no cycle, returns to idle, and leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Chip select, active low; its rising edge commits |
| wp_n | input | 1 | Write-protect pin, active low |
| wren_stb | input | 1 | Set-enable command strobe |
| wrdi_stb | input | 1 | Clear-enable command strobe |
| srw_stb | input | 1 | Status-write command strobe |
| srw_data | input | 8 | Status-write data byte |
| pg_open_stb | input | 1 | Page-write command strobe |
| pg_addr | input | ADDR_W | Page-write start address |
| pg_byte_stb | input | 1 | Page data byte strobe |
| pg_byte | input | 8 | Page data byte |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data (combinational) |
| status | output | 8 | Status byte |
| busy | output | 1 | Write cycle in progress |

## Verification
The hardest case to reach from the ports is a write that has already been committed, then meets the protect pin pulled low and further commands while busy. Reaching it needs a fully accepted page sequence followed by a precisely timed chip-select rise. The bench drives that sequence directly, then holds wp_n low with chip select low and fires set-enable and page-open strobes during the very first busy cycle. It checks that the byte still lands, that the latch ends cleared, and that busy lasts exactly the timer length. Random sequences that mix refused, cancelled, wrapping and lock-crossing page writes then compare the whole array against a bench model.

// File: rtl/nvm_wp_pkg.sv
package nvm_wp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SR_PEND = 2'd1,
        ST_PG_LOAD = 2'd2,
        ST_CYCLE   = 2'd3
    } wp_state_e;

    typedef enum logic [1:0] {
        LOCK_NONE    = 2'b00,
        LOCK_QUARTER = 2'b01,
        LOCK_HALF    = 2'b10,
        LOCK_ALL     = 2'b11
    } lock_code_e;

endpackage

// File: rtl/nvm_wp_timer.sv
module nvm_wp_timer #(
    parameter int CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done,
    output logic running
);
    localparam int TMR_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

    logic [TMR_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= TMR_W'(CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign done    = run_q && (cnt_q == '0);
    assign running = run_q;

    // R4: the cycle keeps running until its count reaches zero
    assert_cycle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != '0 && !start) |=> run_q);

    // R4: a start always launches the cycle
    assert_start_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> run_q);

endmodule

// File: rtl/nvm_wp_pagebuf.sv
module nvm_wp_pagebuf #(
    parameter int PAGE_BYTES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      open,
    input  logic [$clog2(PAGE_BYTES)-1:0] ofs_init,
    input  logic                      byte_stb,
    input  logic [7:0]                byte_in,
    output logic [PAGE_BYTES*8-1:0]   data,
    output logic [PAGE_BYTES-1:0]     mask
);
    localparam int OFS_W = $clog2(PAGE_BYTES);

    logic [OFS_W-1:0]      ofs_q;
    logic [PAGE_BYTES-1:0] mask_q;
    logic [7:0]            slot_q [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            mask_q <= '0;
        end else if (open) begin
            ofs_q  <= ofs_init;
            mask_q <= '0;
        end else if (byte_stb) begin
            mask_q[ofs_q] <= 1'b1;
            ofs_q         <= ofs_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!open && byte_stb) begin
            slot_q[ofs_q] <= byte_in;
        end
    end

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_flat
        assign data[i*8 +: 8] = slot_q[i];
    end

    assign mask = mask_q;

    // R7: the write offset advances by one and wraps inside the page
    assert_ofs_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !open) |=> (ofs_q == $past(ofs_q) + 1'b1));

    // R7: a loaded byte always marks at least one slot valid
    assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !open) |=> (mask_q != '0));

endmodule

// File: rtl/nvm_wp_guard.sv
module nvm_wp_guard
    import nvm_wp_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 16
) (
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page,
    input  lock_code_e                           code,
    output logic [PAGE_BYTES-1:0]                lock
);
    localparam int OFS_W = $clog2(PAGE_BYTES);

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
        logic [ADDR_W-1:0] lane_addr;
        assign lane_addr = {page, OFS_W'(i)};

        always_comb begin
            unique case (code)
                LOCK_NONE:    lock[i] = 1'b0;
                LOCK_QUARTER: lock[i] = lane_addr[ADDR_W-1] & lane_addr[ADDR_W-2];
                LOCK_HALF:    lock[i] = lane_addr[ADDR_W-1];
                LOCK_ALL:     lock[i] = 1'b1;
                default:      lock[i] = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/nvm_wp_array.sv
module nvm_wp_array #(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 16
) (
    input  logic                                 clk,
    input  logic [PAGE_BYTES-1:0]                we,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page,
    input  logic [PAGE_BYTES*8-1:0]              wdata,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [7:0]                           rd_data
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (we[i]) begin
                mem_q[{page, OFS_W'(i)}] <= wdata[i*8 +: 8];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/nvm_wp_ctl.sv
module nvm_wp_ctl
    import nvm_wp_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 16,
    parameter int WC_CYCLES  = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wp_n,
    input  logic              wren_stb,
    input  logic              wrdi_stb,
    input  logic              srw_stb,
    input  logic [7:0]        srw_data,
    input  logic              pg_open_stb,
    input  logic [ADDR_W-1:0] pg_addr,
    input  logic              pg_byte_stb,
    input  logic [7:0]        pg_byte,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [7:0]        status,
    output logic              busy
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFS_W;

    wp_state_e   state_q, state_d;
    logic        wel_q, wel_d;
    lock_code_e  code_q, code_d;
    lock_code_e  code_pend_q, code_pend_d;
    logic        is_page_q, is_page_d;
    logic [PG_W-1:0] page_q, page_d;
    logic        sel_q;

    logic        cs_rise, cancel;
    logic        tmr_start, tmr_done, tmr_run;
    logic        buf_open, buf_byte;
    logic [PAGE_BYTES*8-1:0] buf_data;
    logic [PAGE_BYTES-1:0]   buf_mask, lock_mask, arr_we;

    assign cs_rise = sel_n & ~sel_q;
    assign cancel  = ~sel_n & ~wp_n;

    nvm_wp_timer #(.CYCLES(WC_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .done    (tmr_done),
        .running (tmr_run)
    );

    nvm_wp_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_pagebuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .open     (buf_open),
        .ofs_init (pg_addr[OFS_W-1:0]),
        .byte_stb (buf_byte),
        .byte_in  (pg_byte),
        .data     (buf_data),
        .mask     (buf_mask)
    );

    nvm_wp_guard #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_guard (
        .page (page_q),
        .code (code_q),
        .lock (lock_mask)
    );

    nvm_wp_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk     (clk),
        .we      (arr_we),
        .page    (page_q),
        .wdata   (buf_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            wel_q       <= 1'b0;
            code_q      <= LOCK_NONE;
            code_pend_q <= LOCK_NONE;
            is_page_q   <= 1'b0;
            page_q      <= '0;
            sel_q       <= 1'b1;
        end else begin
            state_q     <= state_d;
            wel_q       <= wel_d;
            code_q      <= code_d;
            code_pend_q <= code_pend_d;
            is_page_q   <= is_page_d;
            page_q      <= page_d;
            sel_q       <= sel_n;
        end
    end

    // Next state and control
    always_comb begin
        state_d     = state_q;
        wel_d       = wel_q;
        code_d      = code_q;
        code_pend_d = code_pend_q;
        is_page_d   = is_page_q;
        page_d      = page_q;
        tmr_start   = 1'b0;
        buf_open    = 1'b0;
        buf_byte    = 1'b0;
        arr_we      = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (wren_stb) begin
                    wel_d = 1'b1;
                end else if (wrdi_stb) begin
                    wel_d = 1'b0;
                end else if (srw_stb) begin
                    if (wel_q && wp_n) begin
                        state_d     = ST_SR_PEND;
                        code_pend_d = lock_code_e'(srw_data[3:2]);
                    end else begin
                        wel_d = 1'b0;
                    end
                end else if (pg_open_stb) begin
                    if (wel_q && wp_n) begin
                        state_d  = ST_PG_LOAD;
                        buf_open = 1'b1;
                        page_d   = pg_addr[ADDR_W-1:OFS_W];
                    end else begin
                        wel_d = 1'b0;
                    end
                end
            end
            ST_SR_PEND: begin
                if (cancel) begin
                    state_d = ST_IDLE;
                    wel_d   = 1'b0;
                end else if (cs_rise) begin
                    state_d   = ST_CYCLE;
                    tmr_start = 1'b1;
                    is_page_d = 1'b0;
                end
            end
            ST_PG_LOAD: begin
                if (cancel) begin
                    state_d = ST_IDLE;
                    wel_d   = 1'b0;
                end else if (cs_rise) begin
                    if (buf_mask != '0) begin
                        state_d   = ST_CYCLE;
                        tmr_start = 1'b1;
                        is_page_d = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (pg_byte_stb) begin
                    buf_byte = 1'b1;
                end
            end
            ST_CYCLE: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                    wel_d   = 1'b0;
                    if (is_page_q) begin
                        arr_we = buf_mask & ~lock_mask;
                    end else begin
                        code_d = code_pend_q;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy   = (state_q == ST_CYCLE);
        status = {4'hF, code_q, wel_q, busy};
    end

    // R4: busy and the timer always agree
    assert_busy_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CYCLE) |-> tmr_run);

    // R3: a cycle only begins with the enable latch set
    assert_enter_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel_q));

    // R4: the latch is clear once a cycle finishes
    assert_wel_clear_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CYCLE && tmr_done) |=> !wel_q);

    // R5: protect pin low with select low cancels a pending sequence
    assert_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SR_PEND || state_q == ST_PG_LOAD) && !sel_n && !wp_n)
        |=> (state_q == ST_IDLE && !wel_q));

    // R10, R6: nothing changes latch or lock code mid-cycle
    assert_busy_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CYCLE && !tmr_done)
        |=> (state_q == ST_CYCLE && $stable(wel_q) && $stable(code_q)));

    // R9: the lock code moves only at the end of a cycle
    assert_code_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == ST_CYCLE && tmr_done) |=> $stable(code_q));

endmodule

// File: tb/nvm_wp_ctl_tb_top.sv
module nvm_wp_ctl_tb_top;
    localparam int CLK_P = 10;
    localparam int AW    = 9;
    localparam int PB    = 16;
    localparam int WC    = 24;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1, wp_n = 1'b1;
    logic          wren_stb = 1'b0, wrdi_stb = 1'b0, srw_stb = 1'b0;
    logic [7:0]    srw_data = '0;
    logic          pg_open_stb = 1'b0, pg_byte_stb = 1'b0;
    logic [AW-1:0] pg_addr = '0, rd_addr = '0;
    logic [7:0]    pg_byte = '0;
    logic [7:0]    rd_data, status;
    logic          busy;

    int         n_chk = 0, n_bad = 0;
    logic [7:0] mdl_mem [DEPTH];
    logic       m_wel = 1'b0;
    logic [1:0] m_code = 2'b00;

    always #(CLK_P/2) clk = ~clk;

    nvm_wp_ctl #(.ADDR_W(AW), .PAGE_BYTES(PB), .WC_CYCLES(WC)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wp_n(wp_n),
        .wren_stb(wren_stb), .wrdi_stb(wrdi_stb), .srw_stb(srw_stb),
        .srw_data(srw_data), .pg_open_stb(pg_open_stb), .pg_addr(pg_addr),
        .pg_byte_stb(pg_byte_stb), .pg_byte(pg_byte), .rd_addr(rd_addr),
        .rd_data(rd_data), .status(status), .busy(busy)
    );

    function automatic bit is_locked(int a, logic [1:0] c);
        case (c)
            2'b00:   return 1'b0;
            2'b01:   return a >= (DEPTH * 3) / 4;
            2'b10:   return a >= DEPTH / 2;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_status(string tag);
        check8(tag, status, {4'hF, m_code, m_wel, 1'b0});
    endtask

    task automatic cmp_mem(string tag);
        int bad = 0;
        logic [7:0] a_v = '0, e_v = '0;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a);
            #1;
            if (rd_data !== mdl_mem[a] && bad == 0) begin
                a_v = rd_data; e_v = mdl_mem[a];
                $display("  first mismatch at %0h", a);
            end
            if (rd_data !== mdl_mem[a]) bad++;
        end
        n_chk++;
        if (bad != 0) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (%0d bytes)", tag, a_v, e_v, bad);
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy === 1'b1 && n < WC + 10) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_wren();
        @(negedge clk); sel_n = 1'b0; wren_stb = 1'b1;
        @(negedge clk); wren_stb = 1'b0; sel_n = 1'b1;
        @(negedge clk);
        m_wel = 1'b1;
    endtask

    task automatic do_wrdi();
        @(negedge clk); sel_n = 1'b0; wrdi_stb = 1'b1;
        @(negedge clk); wrdi_stb = 1'b0; sel_n = 1'b1;
        @(negedge clk);
        m_wel = 1'b0;
    endtask

    task automatic do_srw(logic [7:0] d, bit wp);
        @(negedge clk); sel_n = 1'b0; wp_n = wp; srw_stb = 1'b1; srw_data = d;
        @(negedge clk); srw_stb = 1'b0; sel_n = 1'b1;
        @(negedge clk);
        wait_idle();
        wp_n = 1'b1;
        if (m_wel && wp) m_code = d[3:2];
        m_wel = 1'b0;
    endtask

    task automatic do_page(int addr, int n, bit wp, bit abort);
        logic [7:0]    slot [PB];
        logic [PB-1:0] msk = '0;
        int o = addr % PB;
        @(negedge clk); sel_n = 1'b0; wp_n = wp; pg_open_stb = 1'b1; pg_addr = AW'(addr);
        @(negedge clk); pg_open_stb = 1'b0;
        for (int k = 0; k < n; k++) begin
            pg_byte_stb = 1'b1;
            pg_byte = 8'($urandom);
            slot[o] = pg_byte; msk[o] = 1'b1;
            o = (o + 1) % PB;
            @(negedge clk);
        end
        pg_byte_stb = 1'b0;
        if (abort) begin
            wp_n = 1'b0;
            @(negedge clk);
            wp_n = 1'b1;
        end
        sel_n = 1'b1;
        @(negedge clk);
        wait_idle();
        wp_n = 1'b1;
        if (m_wel && wp) begin
            if (abort) m_wel = 1'b0;
            else if (n > 0) begin
                for (int i = 0; i < PB; i++) begin
                    int a = (addr / PB) * PB + i;
                    if (msk[i] && !is_locked(a, m_code)) mdl_mem[a] = slot[i];
                end
                m_wel = 1'b0;
            end
        end else begin
            m_wel = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int cnt;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check8("R1 reset status", status, 8'hF0);

        do_wren();
        check8("R2 set-enable", status, 8'hF2);
        do_wrdi();
        check8("R2 clear-enable", status, 8'hF0);

        // fill the whole array, lock code 00
        for (int p = 0; p < DEPTH / PB; p++) begin
            do_wren();
            do_page(p * PB, PB, 1'b1, 1'b0);
        end
        cmp_mem("R4 fill");
        chk_status("R4 latch cleared after cycle");

        // R3: no latch -> refused
        do_page(32, 5, 1'b1, 1'b0);
        cmp_mem("R3 refused without latch");
        // R3: protect pin low -> refused, latch cleared
        do_wren();
        do_page(48, 4, 1'b0, 1'b0);
        chk_status("R3 wp low clears latch");
        cmp_mem("R3 wp low blocks write");

        // R4/R6/R10: busy length and commands during the cycle
        do_wren();
        @(negedge clk); sel_n = 1'b0; pg_open_stb = 1'b1; pg_addr = AW'(9'h025);
        @(negedge clk); pg_open_stb = 1'b0; pg_byte_stb = 1'b1; pg_byte = 8'hA5;
        @(negedge clk); pg_byte_stb = 1'b0; sel_n = 1'b1;
        @(negedge clk);
        check8("R1 status while busy", status, 8'hF3);
        wp_n = 1'b0; sel_n = 1'b0; wren_stb = 1'b1; pg_open_stb = 1'b1;
        srw_stb = 1'b1; srw_data = 8'h0C;
        cnt = 1;
        @(negedge clk);
        wren_stb = 1'b0; pg_open_stb = 1'b0; srw_stb = 1'b0;
        while (busy === 1'b1 && cnt < WC + 10) begin
            cnt++;
            @(negedge clk);
        end
        check8("R4 busy length", 8'(cnt), 8'(WC));
        wp_n = 1'b1; sel_n = 1'b1;
        @(negedge clk);
        mdl_mem[9'h025] = 8'hA5;
        m_wel = 1'b0;
        chk_status("R10 R2 commands ignored while busy");
        cmp_mem("R6 committed write survives wp low");

        // R5: cancel mid-load
        do_wren();
        do_page(64 + 3, 5, 1'b1, 1'b1);
        chk_status("R5 cancel clears latch");
        cmp_mem("R5 cancel writes nothing");

        // R7: wrap inside a page
        do_wren();
        do_page(7 * PB + 13, 20, 1'b1, 1'b0);
        cmp_mem("R7 offset wrap");

        // R11: commit with no bytes
        do_wren();
        do_page(200, 0, 1'b1, 1'b0);
        check8("R11 empty commit keeps latch", status, 8'hF2);
        do_wrdi();

        // R8/R9: each lock code
        for (int c = 1; c < 4; c++) begin
            do_wren();
            do_srw(8'hF3 | 8'(c << 2), 1'b1);
            chk_status("R9 lock code from bits 3:2");
            foreach (mdl_mem[i]) begin end
            for (int q = 0; q < 6; q++) begin
                int pa;
                case (q)
                    0: pa = DEPTH / 2 - PB;
                    1: pa = DEPTH / 2;
                    2: pa = (DEPTH * 3) / 4 - PB;
                    3: pa = (DEPTH * 3) / 4;
                    4: pa = DEPTH - PB;
                    default: pa = 0;
                endcase
                do_wren();
                do_page(pa, PB, 1'b1, 1'b0);
            end
            cmp_mem("R8 lock ranges");
        end

        // R3: status write with wp low refused
        do_wren();
        do_srw(8'h00, 1'b0);
        chk_status("R3 status write blocked by wp");
        do_wren();
        do_srw(8'h00, 1'b1);
        check8("R9 lock code cleared", status, 8'hF0);

        // random phase
        for (int it = 0; it < 60; it++) begin
            int op = int'($urandom % 6);
            case (op)
                0: do_wren();
                1: do_wrdi();
                2: do_srw(8'($urandom), ($urandom % 6) != 0);
                default: do_page(int'($urandom % DEPTH), int'($urandom % 21),
                                 ($urandom % 6) != 0, ($urandom % 8) == 0);
            endcase
            chk_status("R2 R3 R9 random status");
            if (it % 10 == 9) cmp_mem("R7 R8 random array");
        end
        cmp_mem("R8 final array");
        finish_run();
    end

endmodule